// File: doc/BRIEF.md
# Packed Double-Precision Predicate Comparator

This block compares two 128-bit operands. Each operand carries two IEEE-754 double-precision values, one in bits 63:0 (the low lane) and one in bits 127:64 (the high lane). A 3-bit predicate code selects one of eight NaN-aware conditions. Each lane that is compared produces a 64-bit mask. The mask is all ones when the condition holds and all zeros when it does not.

In packed mode both lane pairs are compared, and each lane's mask lands in that lane's position. In scalar mode only the low lanes are compared, and the upper 64 bits of the first operand are copied unchanged into the result. An invalid-operation flag reports signaling NaNs. For the four ordering predicates it also reports quiet NaNs. The result and the flag are registered one cycle after an input is accepted through a valid/ready handshake.

Top module: `dpcmp_pred`

## Requirements
- R1: `in_ready` is always high. One cycle after a cycle with `in_valid` high, `out_valid` is high and `res`/`inv_op` hold the new answer. In every other cycle `out_valid` is low and `res`/`inv_op` keep their previous values.
- R2: Predicate codes are: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered. Each condition compares operand A against operand B.
- R3: Each compared lane's 64-bit result field is either all ones (condition true) or all zeros (condition false). The low lane is bits 63:0 and the high lane is bits 127:64.
- R4: A value is a NaN when bits 62:52 are all ones and bits 51:0 are nonzero. A lane is unordered when either input is a NaN. On an unordered lane, codes 0, 1, 2 and 7 give false and codes 3, 4, 5 and 6 give true.
- R5: +0 and -0 compare equal. Other non-NaN values, including infinities, are ordered by sign and magnitude as real numbers.
- R6: When `scalar_mode` is 1, only the low lanes are compared, and `res[127:64]` equals `op_a[127:64]`.
- R7: `inv_op` is set when a compared lane holds a signaling NaN, which is a NaN with bit 51 clear. For codes 1, 2, 5 and 6 it is also set by a quiet NaN, which is a NaN with bit 51 set. In scalar mode, NaNs in the high lane never set it.
- R8: A synchronous active-high `rst` clears `res`, `inv_op` and `out_valid` to zero, and it takes priority over an input handshake.
- R9: In packed mode the two lanes are compared independently of each other with the same predicate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid |
| in_ready | output | 1 | Block accepts input (always high) |
| op_a | input | 128 | First operand, two doubles |
| op_b | input | 128 | Second operand, two doubles |
| pred | input | 3 | Predicate code |
| scalar_mode | input | 1 | 1: low lane only, high half passed from op_a |
| out_valid | output | 1 | Result registered this cycle |
| res | output | 128 | Lane masks (and pass-through in scalar mode) |
| inv_op | output | 1 | Invalid-operation flag |

## Verification
The hardest situation to reach is one where the two lanes must be told apart. Examples are a NaN in the high lane that scalar mode must ignore for both the mask and the invalid flag, and packed inputs whose two lanes give opposite answers. Directed vectors build these cases on purpose. One puts a quiet NaN in the high half of operand A during a scalar ordering compare. Another swaps the values between the lanes, so that only independent evaluation gives the expected mixed mask. A table of single-lane vectors, copied into both lanes, walks the signed-zero, infinity, quiet-NaN and signaling-NaN corners of every predicate.

// File: rtl/dpcmp_pred.sv
module dpcmp_pred #(
  parameter int LANE_W = 64,
  parameter int EXP_W  = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*LANE_W-1:0]   op_a,
  input  logic [2*LANE_W-1:0]   op_b,
  input  logic [2:0]            pred,
  input  logic                  scalar_mode,
  output logic                  out_valid,
  output logic [2*LANE_W-1:0]   res,
  output logic                  inv_op
);
  localparam int FRAC_W = LANE_W - 1 - EXP_W;
  localparam int QBIT   = FRAC_W - 1;

  logic [1:0] hit;
  logic [1:0] bad;

  assign in_ready = 1'b1;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    wire [LANE_W-1:0] a = op_a[i*LANE_W +: LANE_W];
    wire [LANE_W-1:0] b = op_b[i*LANE_W +: LANE_W];
    wire a_nan = (&a[LANE_W-2:FRAC_W]) & (|a[FRAC_W-1:0]);
    wire b_nan = (&b[LANE_W-2:FRAC_W]) & (|b[FRAC_W-1:0]);
    wire unord = a_nan | b_nan;
    wire zz    = ~(|a[LANE_W-2:0]) & ~(|b[LANE_W-2:0]);
    wire eq    = ~unord & ((a == b) | zz);
    wire mag_lt = a[LANE_W-2:0] < b[LANE_W-2:0];
    wire mag_gt = a[LANE_W-2:0] > b[LANE_W-2:0];
    wire ord_lt = (a[LANE_W-1] != b[LANE_W-1]) ? a[LANE_W-1]
                : (a[LANE_W-1] ? mag_gt : mag_lt);
    wire lt    = ~unord & ~zz & ord_lt;
    wire snan  = (a_nan & ~a[QBIT]) | (b_nan & ~b[QBIT]);
    wire strict = (pred[1:0] == 2'd1) | (pred[1:0] == 2'd2);

    always_comb begin
      case (pred)
        3'd0:    hit[i] = eq;
        3'd1:    hit[i] = lt;
        3'd2:    hit[i] = lt | eq;
        3'd3:    hit[i] = unord;
        3'd4:    hit[i] = ~eq;
        3'd5:    hit[i] = ~lt;
        3'd6:    hit[i] = ~(lt | eq);
        default: hit[i] = ~unord;
      endcase
    end

    assign bad[i] = snan | (unord & strict);
  end

  wire [LANE_W-1:0] hi_next = scalar_mode ? op_a[2*LANE_W-1:LANE_W] : {LANE_W{hit[1]}};
  wire              inv_next = bad[0] | (~scalar_mode & bad[1]);
  wire              fire = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      inv_op    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        res    <= {hi_next, {LANE_W{hit[0]}}};
        inv_op <= inv_next;
      end
    end
  end
endmodule

// File: rtl/dpcmp_pred_chk.sv
module dpcmp_pred_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [127:0] op_a,
  input logic         scalar_mode,
  input logic         out_valid,
  input logic [127:0] res,
  input logic         inv_op
);
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready) |=> out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !(in_valid && in_ready) |=> !out_valid); // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) !(in_valid && in_ready) |=> ($stable(res) && $stable(inv_op))); // R1
  AST_LOW_MASK_FULL: assert property (@(posedge clk) disable iff (rst) out_valid |-> (res[63:0] == '0 || res[63:0] == '1)); // R3
  AST_HIGH_MASK_FULL: assert property (@(posedge clk) disable iff (rst) (in_valid && !scalar_mode) |=> (res[127:64] == '0 || res[127:64] == '1)); // R3
  AST_SCALAR_PASS: assert property (@(posedge clk) disable iff (rst) (in_valid && scalar_mode) |=> res[127:64] == $past(op_a[127:64])); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (res == '0 && !inv_op && !out_valid)); // R8
endmodule

bind dpcmp_pred dpcmp_pred_chk u_chk (.*);

// File: tb/dpcmp_pred_bench.sv
`timescale 1ns/100ps
module dpcmp_pred_bench;
  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] NEG1 = 64'hBFF0000000000000;
  localparam logic [63:0] NEG2 = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;

  localparam int NV = 24;
  // {a, b, pred, expected hit, expected invalid}
  localparam logic [132:0] VEC [NV] = '{
    {ONE, ONE, 3'd0, 1'b1, 1'b0}, {ONE, TWO, 3'd0, 1'b0, 1'b0},
    {PZ, NZ, 3'd0, 1'b1, 1'b0},   {ONE, TWO, 3'd1, 1'b1, 1'b0},
    {TWO, ONE, 3'd1, 1'b0, 1'b0}, {NEG2, NEG1, 3'd1, 1'b1, 1'b0},
    {NEG1, ONE, 3'd1, 1'b1, 1'b0},{ONE, ONE, 3'd2, 1'b1, 1'b0},
    {NZ, PZ, 3'd1, 1'b0, 1'b0},   {NZ, PZ, 3'd2, 1'b1, 1'b0},
    {QNAN, ONE, 3'd3, 1'b1, 1'b0},{ONE, ONE, 3'd3, 1'b0, 1'b0},
    {QNAN, ONE, 3'd4, 1'b1, 1'b0},{QNAN, ONE, 3'd5, 1'b1, 1'b1},
    {TWO, ONE, 3'd6, 1'b1, 1'b0}, {ONE, TWO, 3'd6, 1'b0, 1'b0},
    {ONE, QNAN, 3'd7, 1'b0, 1'b0},{PINF, ONE, 3'd7, 1'b1, 1'b0},
    {SNAN, ONE, 3'd0, 1'b0, 1'b1},{QNAN, ONE, 3'd1, 1'b0, 1'b1},
    {NINF, NEG2, 3'd1, 1'b1, 1'b0},{ONE, SNAN, 3'd3, 1'b1, 1'b1},
    {QNAN, QNAN, 3'd0, 1'b0, 1'b0},{ONE, ONE, 3'd4, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic [2:0] pred = '0;
  logic scalar_mode = 1'b0;
  logic out_valid;
  logic [127:0] res;
  logic inv_op;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dpcmp_pred u_dpcmp_pred (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .pred(pred), .scalar_mode(scalar_mode),
    .out_valid(out_valid), .res(res), .inv_op(inv_op)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [2:0] p, input logic s);
    @(negedge clk);
    op_a = a; op_b = b; pred = p; scalar_mode = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(res == '0 && !inv_op && !out_valid, "R8 reset state", res, '0);
    check(in_ready, "R1 ready high", {127'd0, in_ready}, 128'd1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [63:0] va, vb;
      logic [127:0] exp;
      {va, vb} = VEC[i][132:5];
      apply({va, va}, {vb, vb}, VEC[i][4:2], 1'b0);
      exp = {128{VEC[i][1]}};
      check(res == exp, $sformatf("R2/R3/R4/R5 vector %0d mask", i), res, exp);
      check(inv_op == VEC[i][0], $sformatf("R7 vector %0d invalid", i), {127'd0, inv_op}, {127'd0, VEC[i][0]});
    end

    apply({ONE, TWO}, {TWO, ONE}, 3'd1, 1'b0);
    check(res == {{64{1'b1}}, 64'd0}, "R9 lanes independent", res, {{64{1'b1}}, 64'd0});
    check(out_valid, "R1 out_valid after accept", {127'd0, out_valid}, 128'd1);

    @(negedge clk);
    op_a = '0; op_b = {QNAN, QNAN}; pred = 3'd0;
    check(!out_valid, "R1 out_valid drops", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    check(res == {{64{1'b1}}, 64'd0}, "R1 result held without valid", res, {{64{1'b1}}, 64'd0});

    apply({QNAN, ONE}, {TWO, TWO}, 3'd1, 1'b1);
    check(res == {QNAN, {64{1'b1}}}, "R6 scalar pass-through", res, {QNAN, {64{1'b1}}});
    check(!inv_op, "R7 scalar ignores high NaN", {127'd0, inv_op}, 128'd0);

    apply({ONE, QNAN}, {ONE, ONE}, 3'd3, 1'b1);
    check(res == {ONE, {64{1'b1}}}, "R6 scalar unordered low", res, {ONE, {64{1'b1}}});

    apply({QNAN, ONE}, {ONE, ONE}, 3'd6, 1'b0);
    check(inv_op, "R7 packed high quiet NaN ordering", {127'd0, inv_op}, 128'd1);
    check(res == {{64{1'b1}}, 64'd0}, "R4 high unordered NLE", res, {{64{1'b1}}, 64'd0});

    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; op_a = {ONE, ONE}; op_b = {ONE, ONE}; pred = 3'd0;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check(res == '0 && !inv_op && !out_valid, "R8 reset over handshake", res, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule